// File: doc/BRIEF.md
# Receive Pattern Synchronizer and Checker

This block checks a serial test stream from a line under test. It sees one bit per clock cycle in which `bit_en` is high. At the start it builds a local reference generator from the received bits. It then predicts each following bit from the reference and compares the prediction with the bit that arrives. The pattern is set by a tap mask and a register length. These are the same settings the transmitting side uses, so any pseudorandom sequence up to 32 bits long can be tracked.

Synchronization is automatic while the enable is high. A rising edge on the resync control starts a new acquisition at any time. The loss-of-sync output shows the live state of the tracker. Once the block is locked, every mismatching bit gives a one-cycle error strobe. The receive data can be inverted before the comparison. A loopback select checks the local transmit data in place of the receive input. A rising edge on the load input copies the last 32 received bits into a snapshot register that can be read.

Top module: `rx_pattern_sync`

## Requirements
- R1: After reset, `los_o` is 1, `err_o` is 0 and `rx_snap` is all zeros.
- R2: The prediction for each bit is the XOR of the reference bits selected by `taps`. Reference bit k holds the bit received k+1 bits earlier. With `sync_en` high, acquisition first loads `seq_len` received bits into the reference. It then needs `LOCK_RUN` (32) predicted bits in a row with no mismatch. `los_o` falls two cycles after the strobe of the last of these bits, and not one bit earlier.
- R3: `err_o` pulses for exactly one cycle for each mismatching bit, two cycles after that bit's strobe. It pulses only while locked.
- R4: Error windows are fixed, back-to-back blocks of `WIN` (64) bits, counted from the first bit after lock. The sixth mismatch inside one window raises `los_o`. Five mismatches inside one window leave the lock in place.
- R5: After a loss with `sync_en` high, a new acquisition starts by itself with the next bit. It takes `seq_len` + 32 bits.
- R6: After a loss with `sync_en` low, the block stays out of sync no matter what data arrives.
- R7: A 0-to-1 transition of `resync` starts a new acquisition. Holding `resync` high does not start another one. It must return to 0 and rise again.
- R8: With `rx_inv` at 1, the received bit is complemented before it is checked and before it is captured.
- R9: With `loop_sel` at 1, `rx_din` is ignored and `tx_din` is checked in its place.
- R10: A rising edge of `load` copies the last 32 checked bits into `rx_snap`, with the newest bit in bit 0. Holding `load` high does not capture again.
- R11: Cycles with `bit_en` low move no state: no bit is shifted, counted or compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a cycle that carries a data bit |
| rx_din | input | 1 | Received serial data |
| tx_din | input | 1 | Local transmit data, checked in loopback |
| loop_sel | input | 1 | 1 selects `tx_din` in place of `rx_din` |
| rx_inv | input | 1 | 1 complements the selected data |
| sync_en | input | 1 | Enables automatic acquisition |
| resync | input | 1 | Rising edge forces a new acquisition |
| load | input | 1 | Rising edge captures the snapshot |
| taps | input | W | Feedback tap mask of the reference |
| seq_len | input | LEN_W | Reference register length, 1 to W |
| los_o | output | 1 | Loss of sync, active high |
| err_o | output | 1 | One-cycle strobe per mismatched bit while locked |
| rx_snap | output | W | Last W checked bits, newest in bit 0 |

## Verification
The assertions assume that `taps` and `seq_len` stay constant while the block is acquiring or locked. They also assume that all control inputs are synchronous to `clk`. The error-strobe and lock properties depend on a fixed two-stage path from `bit_en` to the outputs. They only hold if `bit_en` is the sole qualifier of data. The bench keeps one nine-stage polynomial for the whole run. It changes `rx_inv`, `loop_sel`, `sync_en`, `resync` and `load` only in idle cycles, between data bits, so each bit is checked under a single, known setting.

// File: rtl/rxps_pkg.sv
package rxps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEED   = 2'd1,
    ST_VERIFY = 2'd2,
    ST_LOCK   = 2'd3
  } sync_state_t;
endpackage

// File: rtl/rxps_front.sv
// Source selection and polarity; registers one bit plus its qualifier.
module rxps_front (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_din,
  input  logic tx_din,
  input  logic loop_sel,
  input  logic rx_inv,
  output logic bit_q,
  output logic vld_q
);
  logic src;
  assign src = loop_sel ? tx_din : rx_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= src ^ rx_inv;
      vld_q <= bit_en;
    end
  end
endmodule

// File: rtl/rxps_snapshot.sv
// History shifter with capture on a rising edge of the load input.
module rxps_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic         din,
  input  logic         load,
  output logic [W-1:0] snap
);
  logic [W-1:0] hist_q;
  logic         load_q;
  logic         load_rise;

  assign load_rise = load & ~load_q;

  always_ff @(posedge clk) load_q <= load;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      snap   <= '0;
    end else begin
      if (vld) hist_q <= {hist_q[W-2:0], din};
      if (load_rise) snap <= hist_q;
    end
  end
endmodule

// File: rtl/rxps_tracker.sv
// Reference generator, acquisition state machine and windowed loss detector.
module rxps_tracker
  import rxps_pkg::*;
#(
  parameter int W         = 32,
  parameter int LEN_W     = 6,
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             din,
  input  logic             sync_en,
  input  logic             resync,
  input  logic [W-1:0]     taps,
  input  logic [LEN_W-1:0] seq_len,
  output logic             los,
  output logic             err
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WIN_W = $clog2(WIN);
  localparam int ERR_W = $clog2(LOSS_ERRS + 1);

  sync_state_t      st;
  logic [W-1:0]     ref_q;
  logic [LEN_W-1:0] seed_cnt;
  logic [RUN_W-1:0] run_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [ERR_W-1:0] err_cnt;
  logic             resync_q;
  logic             resync_rise;
  logic             pred;
  logic             miss;

  assign resync_rise = resync & ~resync_q;
  assign pred        = ^(ref_q & taps);
  assign miss        = din ^ pred;
  assign los         = (st != ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ref_q    <= '0;
      seed_cnt <= '0;
      run_cnt  <= '0;
      win_cnt  <= '0;
      err_cnt  <= '0;
      resync_q <= 1'b0;
      err      <= 1'b0;
    end else begin
      resync_q <= resync;
      err      <= 1'b0;
      if (resync_rise) begin
        st       <= ST_SEED;
        seed_cnt <= '0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (sync_en) begin
              st       <= ST_SEED;
              seed_cnt <= '0;
            end
          end
          ST_SEED: begin
            if (vld) begin
              ref_q <= {ref_q[W-2:0], din};
              if (seed_cnt == seq_len - LEN_W'(1)) begin
                st      <= ST_VERIFY;
                run_cnt <= '0;
              end else begin
                seed_cnt <= seed_cnt + LEN_W'(1);
              end
            end
          end
          ST_VERIFY: begin
            if (vld) begin
              ref_q <= {ref_q[W-2:0], pred};
              if (miss) begin
                st       <= ST_SEED;
                seed_cnt <= '0;
              end else if (run_cnt == RUN_W'(LOCK_RUN - 1)) begin
                st      <= ST_LOCK;
                win_cnt <= '0;
                err_cnt <= '0;
              end else begin
                run_cnt <= run_cnt + RUN_W'(1);
              end
            end
          end
          ST_LOCK: begin
            if (vld) begin
              ref_q <= {ref_q[W-2:0], pred};
              err   <= miss;
              if (miss && err_cnt == ERR_W'(LOSS_ERRS - 1)) begin
                st       <= sync_en ? ST_SEED : ST_IDLE;
                seed_cnt <= '0;
              end else if (win_cnt == WIN_W'(WIN - 1)) begin
                win_cnt <= '0;
                err_cnt <= '0;
              end else begin
                win_cnt <= win_cnt + WIN_W'(1);
                err_cnt <= err_cnt + ERR_W'(miss);
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_pattern_sync.sv
module rx_pattern_sync #(
  parameter int W         = 32,
  parameter int LEN_W     = $clog2(W + 1),
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             rx_din,
  input  logic             tx_din,
  input  logic             loop_sel,
  input  logic             rx_inv,
  input  logic             sync_en,
  input  logic             resync,
  input  logic             load,
  input  logic [W-1:0]     taps,
  input  logic [LEN_W-1:0] seq_len,
  output logic             los_o,
  output logic             err_o,
  output logic [W-1:0]     rx_snap
);
  logic chk_bit;
  logic chk_vld;

  rxps_front u_front (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .rx_din   (rx_din),
    .tx_din   (tx_din),
    .loop_sel (loop_sel),
    .rx_inv   (rx_inv),
    .bit_q    (chk_bit),
    .vld_q    (chk_vld)
  );

  rxps_tracker #(
    .W         (W),
    .LEN_W     (LEN_W),
    .LOCK_RUN  (LOCK_RUN),
    .WIN       (WIN),
    .LOSS_ERRS (LOSS_ERRS)
  ) u_track (
    .clk     (clk),
    .rst     (rst),
    .vld     (chk_vld),
    .din     (chk_bit),
    .sync_en (sync_en),
    .resync  (resync),
    .taps    (taps),
    .seq_len (seq_len),
    .los     (los_o),
    .err     (err_o)
  );

  rxps_snapshot #(.W(W)) u_snap (
    .clk  (clk),
    .rst  (rst),
    .vld  (chk_vld),
    .din  (chk_bit),
    .load (load),
    .snap (rx_snap)
  );
endmodule

// File: rtl/rx_pattern_sync_chk.sv
module rx_pattern_sync_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_en,
  input logic         load,
  input logic         los_o,
  input logic         err_o,
  input logic [W-1:0] rx_snap
);
  assert_err_needs_bit_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(bit_en, 2));

  assert_err_only_locked_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(!los_o));

  assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(los_o) |-> $past(bit_en, 2));

  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(load && !$past(load)) |=> $stable(rx_snap));
endmodule

bind rx_pattern_sync rx_pattern_sync_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_en  (bit_en),
  .load    (load),
  .los_o   (los_o),
  .err_o   (err_o),
  .rx_snap (rx_snap)
);

// File: tb/test_rx_pattern_sync.sv
module test_rx_pattern_sync;
  localparam int W = 32;
  localparam int LEN_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, rx_din = 1'b0, tx_din = 1'b0;
  logic loop_sel = 1'b0, rx_inv = 1'b0, sync_en = 1'b1, resync = 1'b0, load = 1'b0;
  logic [W-1:0] taps = 32'h0000_0110;  // b[n] = b[n-9] ^ b[n-5]
  logic [LEN_W-1:0] seq_len = 6'd9;
  logic los_o, err_o;
  logic [W-1:0] rx_snap;

  rx_pattern_sync i_rx_pattern_sync (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_din(rx_din), .tx_din(tx_din),
    .loop_sel(loop_sel), .rx_inv(rx_inv), .sync_en(sync_en), .resync(resync),
    .load(load), .taps(taps), .seq_len(seq_len),
    .los_o(los_o), .err_o(err_o), .rx_snap(rx_snap)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  logic [31:0] sh = 32'h0000_01FF;
  logic [31:0] effhist = '0;
  logic chk_flag = 1'b0;
  logic [1:0] chk_pipe = '0;
  logic exp_q[$];
  string tag_q[$];
  logic done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one bit per call, optionally corrupted, expected strobe queued
  task automatic send(input logic flip, input logic chk, input logic exp, input string tag);
    logic t, d;
    @(negedge clk);
    t = sh[8] ^ sh[4];
    sh = {sh[30:0], t};
    d = t ^ flip;
    effhist = {effhist[30:0], d};
    if (loop_sel) begin
      tx_din = d;
      rx_din = ~d;
    end else begin
      rx_din = d ^ rx_inv;
      tx_din = ~d;
    end
    bit_en = 1'b1;
    chk_flag = chk;
    if (chk) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0;
      chk_flag = 1'b0;
    end
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares the strobe two edges after each checked bit
  always @(posedge clk) chk_pipe <= {chk_pipe[0], bit_en & chk_flag};

  always @(negedge clk) begin
    if (chk_pipe[1]) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R3: actual strobe with empty queue expected none");
      end else begin
        logic e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, {31'd0, err_o}, {31'd0, e});
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 los", {31'd0, los_o}, 32'd1);
    check("R1 err", {31'd0, err_o}, 32'd0);
    check("R1 snap", rx_snap, 32'd0);

    // R2 acquisition: 9 seed + 32 verify bits, with an idle gap (R11)
    for (int i = 0; i < 40; i++) begin
      send(1'b0, 1'b1, 1'b0, "R2");
      if (i == 20) idle(3);
    end
    idle(3);
    check("R2 not yet locked (R11 gap)", {31'd0, los_o}, 32'd1);
    send(1'b0, 1'b1, 1'b0, "R2");
    idle(3);
    check("R2 locked", {31'd0, los_o}, 32'd0);

    // R3/R4: five errors in window of bits 41..104
    for (int i = 41; i <= 104; i++) begin
      logic f;
      f = (i == 45 || i == 50 || i == 60 || i == 70 || i == 80);
      send(f, 1'b1, f, "R3");
    end
    idle(3);
    check("R4 five errors keep lock", {31'd0, los_o}, 32'd0);

    // R4: six errors in window 105..168 (bits 110..115)
    for (int i = 105; i <= 115; i++) begin
      logic f;
      f = (i >= 110);
      send(f, 1'b1, f, "R4");
    end
    idle(3);
    check("R4 sixth error drops lock", {31'd0, los_o}, 32'd1);

    // R5: automatic reacquire
    for (int i = 0; i < 40; i++) send(1'b0, 1'b1, 1'b0, "R5");
    idle(3);
    check("R5 still acquiring", {31'd0, los_o}, 32'd1);
    send(1'b0, 1'b1, 1'b0, "R5");
    idle(3);
    check("R5 relocked", {31'd0, los_o}, 32'd0);

    // R8: inverted line, gaps between bits
    rx_inv = 1'b1;
    idle(2);
    for (int i = 0; i < 40; i++) begin
      send(1'b0, 1'b1, 1'b0, "R8");
      if (i % 4 == 3) idle(2);
    end
    idle(3);
    check("R8 lock kept under inversion", {31'd0, los_o}, 32'd0);
    pulse_load();
    check("R10 snapshot", rx_snap, effhist);
    begin
      logic [31:0] held;
      held = rx_snap;
      @(negedge clk); load = 1'b1;
      for (int i = 0; i < 5; i++) send(1'b0, 1'b1, 1'b0, "R8");
      idle(3);
      check("R10 held load no recapture", rx_snap, held);
      load = 1'b0;
    end

    // R9: loopback, rx_din carries the complement
    rx_inv = 1'b0;
    loop_sel = 1'b1;
    idle(2);
    for (int i = 0; i < 40; i++) send(1'b0, 1'b1, 1'b0, "R9");
    idle(3);
    check("R9 loopback lock kept", {31'd0, los_o}, 32'd0);
    pulse_load();
    check("R10 R9 snapshot of loop data", rx_snap, effhist);

    // R6: no automatic acquisition with sync_en low
    sync_en = 1'b0;
    idle(2);
    for (int i = 0; i < 11; i++) send(1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 60; i++) send(1'b0, 1'b1, 1'b0, "R6");
    idle(3);
    check("R6 stays out of sync", {31'd0, los_o}, 32'd1);

    // R7: resync rising edge
    resync = 1'b1;
    idle(2);
    for (int i = 0; i < 40; i++) send(1'b0, 1'b1, 1'b0, "R7");
    idle(3);
    check("R7 acquiring after resync", {31'd0, los_o}, 32'd1);
    send(1'b0, 1'b1, 1'b0, "R7");
    idle(3);
    check("R7 locked after resync", {31'd0, los_o}, 32'd0);
    for (int i = 0; i < 11; i++) send(1'b1, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 60; i++) send(1'b0, 1'b1, 1'b0, "R7");
    idle(3);
    check("R7 held resync no retrigger", {31'd0, los_o}, 32'd1);
    resync = 1'b0;
    idle(2);
    resync = 1'b1;
    idle(2);
    for (int i = 0; i < 41; i++) send(1'b0, 1'b1, 1'b0, "R7");
    idle(3);
    check("R7 second edge relocks", {31'd0, los_o}, 32'd0);

    idle(4);
    check("R3 all strobes seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule